// File: doc/BRIEF.md
# Dual-Line Optical Black Clamp

This block sits on the digitized sample stream of one colour channel of a linear image sensor that has two staggered pixel rows, a main row and a sub row, sharing one output. Samples of the two rows arrive interleaved, main first, each marked by a valid strobe. A start-of-line pulse marks the first sample of a line. A run of shielded (optical black) pixel pairs comes near the start of every line. The block averages the shielded samples of each row separately to obtain two black references.

After the shielded run comes a window of effective pixel pairs. The block subtracts the matching reference from every effective sample, stopping at zero, and sends main results and sub results to separate output strobes. It also reports the absolute difference between the two references and raises a flag when that difference is above a limit given by the host. The flag stays up until the next line starts.

Position in the line is tracked by a state machine with a pair counter and a one-bit row toggle. The states are ST_IDLE (no line seen since reset), ST_LEAD (dummy pairs before the shielded run), ST_BLACK (shielded pairs are summed), ST_GAP (dummy pairs between the shielded run and the effective window), ST_ACTIVE (effective pairs are corrected) and ST_DONE (trailing pairs are ignored). The transitions are:
- start-of-line from any state goes to ST_LEAD;
- ST_LEAD goes to ST_BLACK after pair OB_START-1;
- ST_BLACK goes to ST_GAP after its last shielded pair, or straight to ST_ACTIVE when no gap pairs are configured;
- ST_GAP goes to ST_ACTIVE after pair EFF_START-1;
- ST_ACTIVE goes to ST_DONE after its last effective pair.

The start-of-line sample counts as main sample of pair 0, so OB_START must be at least 1.

Top module: `dual_ob_clamp`

## Requirements
- R1: After reset every output is zero: no output strobe, both black levels zero, difference zero and flag low.
- R2: The sample carrying in_sol with in_valid is the main sample of pair 0. Later valid samples alternate sub, main, sub and so on. A cycle with in_valid low changes nothing.
- R3: The main black level is the sum of the OB_LEN main samples of pairs OB_START to OB_START+OB_LEN-1, shifted right by log2(OB_LEN). The sub black level is formed the same way from the sub samples of those pairs. Defaults are OB_START=23, OB_LEN=16, EFF_START=44 and EFF_LEN=5350, with pair numbering starting at 0.
- R4: For a main sample of a pair in EFF_START to EFF_START+EFF_LEN-1, main_valid is high in the cycle after the sample and main_data equals the sample minus the main black level. Sub samples behave the same way on sub_valid and sub_data with the sub black level.
- R5: When a sample is below its black level, the corrected output is zero. It never wraps.
- R6: Dummy samples, shielded samples and samples after the effective window raise no output strobe.
- R7: Both black levels change only together, in the cycle after the last shielded sub sample of a line. A line restarted before its shielded run is complete leaves the previous levels unchanged.
- R8: black_diff equals the absolute difference of the two black levels and updates with them.
- R9: mismatch rises with the level update when black_diff is strictly greater than mismatch_limit. It stays high until the cycle after the next start-of-line sample, when it is low.
- R10: Valid samples before the first start-of-line since reset produce no output and change no black level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Sample strobe |
| in_sol | input | 1 | Start of line, set with the first main sample |
| in_data | input | DW | Digitized sample |
| mismatch_limit | input | DW | Largest black-level difference that is accepted |
| main_valid | output | 1 | Corrected main sample strobe |
| main_data | output | DW | Corrected main sample |
| sub_valid | output | 1 | Corrected sub sample strobe |
| sub_data | output | DW | Corrected sub sample |
| black_main | output | DW | Current main black level |
| black_sub | output | DW | Current sub black level |
| black_diff | output | DW | Absolute difference of the black levels |
| mismatch | output | 1 | Difference above limit, held for the line |

## Verification
An error in the pair counter or the row toggle moves the effective window or swaps the rows. The first effective pair then shows the wrong strobe or a value offset by the other row's level, within one cycle of the sample. A wrong accumulator, or a level update at the wrong moment, shows on black_main and black_sub in the cycle after the last shielded sub sample, and it also shifts every corrected pixel of that line. A flag that is not cleared, or set on the wrong side of the limit, is visible one cycle after the start-of-line sample or one cycle after the level update.

// File: rtl/obc_pkg.sv
package obc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_BLACK,
        ST_GAP,
        ST_ACTIVE,
        ST_DONE
    } region_e;
endpackage

// File: rtl/obc_sequencer.sv
module obc_sequencer
    import obc_pkg::*;
#(
    parameter int OB_START  = 23,
    parameter int OB_LEN    = 16,
    parameter int EFF_START = 44,
    parameter int EFF_LEN   = 5350
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_sol,
    output logic acc_clr,
    output logic acc_en_main,
    output logic acc_en_sub,
    output logic commit,
    output logic pix_main,
    output logic pix_sub
);
    localparam int OB_END    = OB_START + OB_LEN;
    localparam int LAST_PAIR = EFF_START + EFF_LEN - 1;
    localparam int CW        = $clog2(LAST_PAIR + 2);
    localparam logic [CW-1:0] LEAD_LAST = CW'(OB_START - 1);
    localparam logic [CW-1:0] OB_LAST   = CW'(OB_END - 1);
    localparam logic [CW-1:0] GAP_LAST  = CW'(EFF_START - 1);
    localparam logic [CW-1:0] EFF_LAST  = CW'(LAST_PAIR);
    localparam region_e AFTER_BLACK = (EFF_START == OB_END) ? ST_ACTIVE : ST_GAP;

    region_e         state_q, state_d;
    logic [CW-1:0]   cnt_q, cnt_d;
    logic            side_q, side_d;   // 0 = main sample expected, 1 = sub
    logic            start, step;

    assign start = in_valid && in_sol;
    assign step  = in_valid && !in_sol && (state_q != ST_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            side_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            side_q  <= side_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        side_d  = side_q;
        if (start) begin
            state_d = ST_LEAD;
            cnt_d   = '0;
            side_d  = 1'b1;
        end else if (step) begin
            side_d = ~side_q;
            if (side_q) begin
                if (state_q != ST_DONE) begin
                    cnt_d = cnt_q + 1'b1;
                end
                unique case (state_q)
                    ST_IDLE:   state_d = ST_IDLE;
                    ST_LEAD:   if (cnt_q == LEAD_LAST) state_d = ST_BLACK;
                    ST_BLACK:  if (cnt_q == OB_LAST)   state_d = AFTER_BLACK;
                    ST_GAP:    if (cnt_q == GAP_LAST)  state_d = ST_ACTIVE;
                    ST_ACTIVE: if (cnt_q == EFF_LAST)  state_d = ST_DONE;
                    ST_DONE:   state_d = ST_DONE;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        acc_clr     = start;
        acc_en_main = step && (state_q == ST_BLACK) && !side_q;
        acc_en_sub  = step && (state_q == ST_BLACK) &&  side_q;
        commit      = step && (state_q == ST_BLACK) &&  side_q && (cnt_q == OB_LAST);
        pix_main    = step && (state_q == ST_ACTIVE) && !side_q;
        pix_sub     = step && (state_q == ST_ACTIVE) &&  side_q;
    end
endmodule

// File: rtl/obc_accum.sv
module obc_accum #(
    parameter int DW     = 12,
    parameter int OB_LEN = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr,
    input  logic                          en,
    input  logic [DW-1:0]                 din,
    output logic [DW+$clog2(OB_LEN)-1:0]  sum_next
);
    localparam int SH = $clog2(OB_LEN);
    localparam int SW = DW + SH;

    logic [SW-1:0] sum_q;

    always_comb begin
        sum_next = en ? (sum_q + {{SH{1'b0}}, din}) : sum_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   sum_q <= '0;
        else if (clr) sum_q <= '0;
        else          sum_q <= sum_next;
    end
endmodule

// File: rtl/obc_mismatch.sv
module obc_mismatch #(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          commit,
    input  logic [DW-1:0] lvl_main,
    input  logic [DW-1:0] lvl_sub,
    input  logic [DW-1:0] limit,
    output logic [DW-1:0] diff,
    output logic          flag
);
    logic [DW-1:0] gap;

    always_comb begin
        gap = (lvl_main >= lvl_sub) ? (lvl_main - lvl_sub) : (lvl_sub - lvl_main);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            diff <= '0;
            flag <= 1'b0;
        end else begin
            if (commit) begin
                diff <= gap;
                flag <= (gap > limit);
            end else if (clr) begin
                flag <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dual_ob_clamp.sv
module dual_ob_clamp #(
    parameter int DW        = 12,
    parameter int OB_START  = 23,
    parameter int OB_LEN    = 16,
    parameter int EFF_START = 44,
    parameter int EFF_LEN   = 5350
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_sol,
    input  logic [DW-1:0] in_data,
    input  logic [DW-1:0] mismatch_limit,
    output logic          main_valid,
    output logic [DW-1:0] main_data,
    output logic          sub_valid,
    output logic [DW-1:0] sub_data,
    output logic [DW-1:0] black_main,
    output logic [DW-1:0] black_sub,
    output logic [DW-1:0] black_diff,
    output logic          mismatch
);
    localparam int SH = $clog2(OB_LEN);
    localparam int SW = DW + SH;

    logic          acc_clr, acc_en_main, acc_en_sub, commit, pix_main, pix_sub;
    logic [1:0]    acc_en;
    logic [SW-1:0] sum_next [2];
    logic [DW-1:0] avg      [2];

    obc_sequencer #(
        .OB_START (OB_START),
        .OB_LEN   (OB_LEN),
        .EFF_START(EFF_START),
        .EFF_LEN  (EFF_LEN)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_sol     (in_sol),
        .acc_clr    (acc_clr),
        .acc_en_main(acc_en_main),
        .acc_en_sub (acc_en_sub),
        .commit     (commit),
        .pix_main   (pix_main),
        .pix_sub    (pix_sub)
    );

    assign acc_en = {acc_en_sub, acc_en_main};

    for (genvar g = 0; g < 2; g++) begin : g_row
        obc_accum #(.DW(DW), .OB_LEN(OB_LEN)) u_acc (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (acc_clr),
            .en      (acc_en[g]),
            .din     (in_data),
            .sum_next(sum_next[g])
        );
        assign avg[g] = sum_next[g][SW-1:SH];
    end

    obc_mismatch #(.DW(DW)) u_mis (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (acc_clr),
        .commit  (commit),
        .lvl_main(avg[0]),
        .lvl_sub (avg[1]),
        .limit   (mismatch_limit),
        .diff    (black_diff),
        .flag    (mismatch)
    );

    function automatic logic [DW-1:0] clamp_sub(input logic [DW-1:0] s, input logic [DW-1:0] b);
        return (s > b) ? (s - b) : '0;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            black_main <= '0;
            black_sub  <= '0;
        end else if (commit) begin
            black_main <= avg[0];
            black_sub  <= avg[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            main_valid <= 1'b0;
            sub_valid  <= 1'b0;
            main_data  <= '0;
            sub_data   <= '0;
        end else begin
            main_valid <= pix_main;
            sub_valid  <= pix_sub;
            if (pix_main) main_data <= clamp_sub(in_data, black_main);
            if (pix_sub)  sub_data  <= clamp_sub(in_data, black_sub);
        end
    end
endmodule

// File: rtl/obc_clamp_checker.sv
module obc_clamp_checker #(
    parameter int DW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_sol,
    input logic [DW-1:0] in_data,
    input logic          main_valid,
    input logic [DW-1:0] main_data,
    input logic          sub_valid,
    input logic [DW-1:0] sub_data,
    input logic [DW-1:0] black_main,
    input logic [DW-1:0] black_sub,
    input logic [DW-1:0] black_diff,
    input logic          mismatch
);
    // R2: one sample per cycle, so only one row can produce a result
    p_one_row_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(main_valid && sub_valid));

    // R4: a result always follows an accepted sample
    p_valid_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (main_valid || sub_valid) |-> $past(in_valid));

    // R5: subtraction never exceeds the sample (no wrap)
    p_no_wrap_main_r5: assert property (@(posedge clk) disable iff (!rst_n)
        main_valid |-> (main_data <= $past(in_data)));
    p_no_wrap_sub_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sub_valid |-> (sub_data <= $past(in_data)));

    // R7: levels stay put when no sample was accepted
    p_level_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> ($stable(black_main) && $stable(black_sub)));

    // R8: reported difference tracks the levels
    p_diff_r8: assert property (@(posedge clk) disable iff (!rst_n)
        black_diff == ((black_main >= black_sub) ? (black_main - black_sub)
                                                 : (black_sub - black_main)));

    // R9: flag cleared by a new line, held otherwise
    p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sol) |=> !mismatch);
    p_flag_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mismatch && !(in_valid && in_sol)) |=> mismatch);
endmodule

bind dual_ob_clamp obc_clamp_checker #(.DW(DW)) u_obc_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sol    (in_sol),
    .in_data   (in_data),
    .main_valid(main_valid),
    .main_data (main_data),
    .sub_valid (sub_valid),
    .sub_data  (sub_data),
    .black_main(black_main),
    .black_sub (black_sub),
    .black_diff(black_diff),
    .mismatch  (mismatch)
);

// File: tb/dual_ob_clamp_bench.sv
`timescale 1ns/1ps
module dual_ob_clamp_bench;
    localparam int DW        = 12;
    localparam int OB_START  = 2;
    localparam int OB_LEN    = 16;
    localparam int EFF_START = 20;
    localparam int EFF_LEN   = 6;
    localparam int FULL      = EFF_START + EFF_LEN + 2;
    localparam int DUMMY     = 3000;

    // mob, sob, mpx, spx, limit
    localparam int TBL [4][5] = '{
        '{100,  90, 300,  50,   5},
        '{ 40,  40,  20, 200,   0},
        '{500, 480, 600, 470,  20},
        '{4000,  0, 4050, 10, 100}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_sol = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic [DW-1:0] mismatch_limit = '0;
    logic          main_valid, sub_valid, mismatch;
    logic [DW-1:0] main_data, sub_data, black_main, black_sub, black_diff;

    int checks = 0;
    int fails  = 0;
    int bm = 0;
    int bs = 0;

    always #2 clk = ~clk;

    dual_ob_clamp #(
        .DW(DW), .OB_START(OB_START), .OB_LEN(OB_LEN),
        .EFF_START(EFF_START), .EFF_LEN(EFF_LEN)
    ) u_dual_ob_clamp (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sol(in_sol),
        .in_data(in_data), .mismatch_limit(mismatch_limit),
        .main_valid(main_valid), .main_data(main_data),
        .sub_valid(sub_valid), .sub_data(sub_data),
        .black_main(black_main), .black_sub(black_sub),
        .black_diff(black_diff), .mismatch(mismatch)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // kind: 0 none, 1 main result, 2 sub result
    task automatic send(input bit sol, input int d, input int kind, input int expd, input string req);
        int act;
        @(negedge clk);
        in_valid = 1'b1;
        in_sol   = sol;
        in_data  = DW'(d);
        @(negedge clk);
        in_valid = 1'b0;
        in_sol   = 1'b0;
        act = kind == 1 ? int'(main_data) : (kind == 2 ? int'(sub_data) : 0);
        chk(main_valid == (kind == 1) && sub_valid == (kind == 2) && (kind == 0 || act == expd),
            req, {main_valid, sub_valid} * 10000 + act, kind * 10000 + expd);
    endtask

    function automatic int clampv(input int s, input int b);
        return (s > b) ? s - b : 0;
    endfunction

    task automatic run_line(input int mob, input int sob, input int mpx, input int spx,
                            input int lim, input int npairs);
        int sm = 0, ss = 0, nbm, nbs, d;
        for (int k = 0; k < OB_LEN; k++) begin
            sm += mob + (k & 3);
            ss += sob + (k & 3);
        end
        nbm = sm / OB_LEN;
        nbs = ss / OB_LEN;
        mismatch_limit = DW'(lim);
        for (int p = 0; p < npairs; p++) begin
            for (int side = 0; side < 2; side++) begin
                int base = side ? sob : mob;
                int pix  = side ? spx : mpx;
                int step = side ? 5 : 7;
                int lvl  = side ? nbs : nbm;
                if (p >= OB_START && p < OB_START + OB_LEN) begin
                    send(p == 0 && side == 0, base + ((p - OB_START) & 3), 0, 0, "R6 black");
                end else if (p >= EFF_START && p < EFF_START + EFF_LEN) begin
                    d = pix + step * (p - EFF_START);
                    send(1'b0, d, side + 1, clampv(d, lvl),
                         d > lvl ? (side ? "R4 R2 sub" : "R4 main") : "R5 clamp");
                end else begin
                    send(p == 0 && side == 0, DUMMY, 0, 0, "R6 dummy");
                end
                if (p == 0 && side == 0)
                    chk(mismatch == 1'b0, "R9 clear", int'(mismatch), 0);
            end
        end
        if (npairs >= OB_START + OB_LEN) begin
            bm = nbm;
            bs = nbs;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!main_valid && !sub_valid && main_data == 0 && sub_data == 0, "R1 outputs", int'(main_data), 0);
        chk(black_main == 0 && black_sub == 0 && black_diff == 0 && !mismatch, "R1 levels",
            int'(black_main) + int'(black_sub), 0);

        // R10: stream before the first start-of-line is ignored
        for (int i = 0; i < 40; i++) send(1'b0, 50 + i, 0, 0, "R10 pre-line");
        chk(black_main == 0 && black_sub == 0, "R10 levels", int'(black_main), 0);

        // table of full lines
        for (int t = 0; t < 4; t++) begin
            run_line(TBL[t][0], TBL[t][1], TBL[t][2], TBL[t][3], TBL[t][4], FULL);
            chk(int'(black_main) == bm, "R3 main level", int'(black_main), bm);
            chk(int'(black_sub) == bs, "R3 sub level", int'(black_sub), bs);
            chk(int'(black_diff) == (bm > bs ? bm - bs : bs - bm), "R8 diff", int'(black_diff),
                bm > bs ? bm - bs : bs - bm);
            chk(mismatch == ((bm > bs ? bm - bs : bs - bm) > TBL[t][4]), "R9 flag", int'(mismatch),
                int'((bm > bs ? bm - bs : bs - bm) > TBL[t][4]));
        end

        // R7: line cut short inside its black run keeps old levels
        run_line(7, 9, 0, 0, 0, OB_START + 5);
        chk(int'(black_main) == bm && int'(black_sub) == bs, "R7 hold", int'(black_main), bm);
        chk(mismatch == 1'b0, "R9 held low after restart", int'(mismatch), 0);

        // recovery with a full line after the cut one
        run_line(TBL[0][0], TBL[0][1], TBL[0][2], TBL[0][3], TBL[0][4], FULL);
        chk(int'(black_main) == bm && int'(black_sub) == bs, "R7 update", int'(black_sub), bs);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule